// File: doc/BRIEF.md
# I2C Bit-Clock Divider with Standard and Fast Timing

This block turns a fast system clock into the SCL waveform of an I2C master. A 12-bit divider value is assembled from two 8-bit configuration registers, and a mode bit chooses between two period formulas. Standard timing gives a period of 2×D+7 system clocks and fast timing gives 3×D+9, where D is the divider. The block drives SCL low through an open-drain style output. It also emits two single-cycle strobes: one marks the point at which the data line may change, and the other marks the point at which it should be sampled.

The block senses the real level of SCL on a separate input. After the block releases the line, its high-phase timer does not advance while the line still reads low, so a slave that stretches the clock simply lengthens the high phase. The divider and mode are captured at the start of every period, so a register write during a period changes only the periods that follow. Divider values below 2 are refused: the line is never pulled low for them. A separate 3-bit field records the band of the system clock frequency for use by neighbouring logic.

Top module: `scl_divider_top`

## Requirements
- R1: A write with `wr_sel`=0 loads the rate register: bit 7 selects fast timing and bits 6:0 become divider bits 6:0. A write with `wr_sel`=1 loads divider bits 11:7 from data bits 4:0, and data bits 7:5 are ignored. A write with `wr_sel`=3 changes nothing.
- R2: With standard timing and divider D≥2, each period drives SCL low for D+4 clocks and releases it for D+3 clocks, for a total of 2D+7.
- R3: With fast timing and divider D≥2, each period drives SCL low for 2D+6 clocks and releases it for D+3 clocks, for a total of 3D+9.
- R4: While the divider is 0 or 1, SCL is never driven low. A period that ends with such a divider programmed is followed by an idle, released line.
- R5: While the line is released, the high-phase count advances only in cycles in which `scl_in` reads high. Each cycle of held-low stretch adds one clock to the released time.
- R6: `sda_change_stb` pulses exactly once per period, in the second clock of the low phase.
- R7: `sda_sample_stb` pulses exactly once per high phase, with `scl_in` high. It falls in released cycle H−1−⌊(H−1)/2⌋ counted from 0, where H=D+3, and is shifted later by any stretch cycles.
- R8: A write with `wr_sel`=2 loads the 3-bit clock-band field from data bits 7:5 and ignores bits 4:0. The field resets to 010 and is output on `clk_band`.
- R9: With `enable` low, the line is released from the next clock onward. When `enable` rises with a legal divider, SCL is driven low from the next clock.
- R10: The divider and mode are captured when a low phase begins. A write during a period affects the next period only.
- R11: After reset, SCL is released, both strobes are low, and the divider is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the bit clock when high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 rate, 1 rate extension, 2 clock band |
| wr_data | input | 8 | Register write data |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_drive_low | output | 1 | Pull SCL low when high |
| sda_change_stb | output | 1 | Strobe: data line may change |
| sda_sample_stb | output | 1 | Strobe: sample the data line |
| clk_band | output | 3 | Programmed system clock band code |

## Verification
The bench measures the low time and released time of whole periods in both modes. It covers the smallest legal divider, dividers that reach into the extension register with junk in its upper bits, and a random spread of values, so a wrong overhead or a wrong mode multiplier appears as an off-by-N length. A divider of 0 or 1, both from idle and at a period boundary, must leave the line released; a design that lets such a divider through would produce a runaway fast clock. Held-low stretches must lengthen the released time by exactly the stretch and move the sample strobe by the same amount; a timer that keeps running through the stretch would cut the high phase short. A write in the middle of a period must leave that period's timing unchanged, which catches a design that reads live registers.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    localparam int REG_W    = 8;
    localparam int LO_W     = 7;
    localparam int HI_W     = 5;
    localparam int DIV_W    = LO_W + HI_W;
    localparam int CNT_W    = DIV_W + 2;
    localparam int BAND_W   = 3;
    localparam int MIN_DIV  = 2;
    localparam int STD_LOW_OVH  = 4;
    localparam int FAST_LOW_OVH = 6;
    localparam int HIGH_OVH     = 3;
    localparam logic [BAND_W-1:0] BAND_RST = 3'b010;

    typedef enum logic [1:0] {
        SEL_RATE     = 2'd0,
        SEL_RATE_EXT = 2'd1,
        SEL_BAND     = 2'd2,
        SEL_NONE     = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic             fast;
        logic [DIV_W-1:0] div;
    } rate_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] low_len;
        logic [CNT_W-1:0] high_len;
        logic             legal;
    } phase_len_t;

    function automatic logic [CNT_W-1:0] low_len_f(rate_cfg_t c);
        logic [CNT_W-1:0] d;
        d = {2'b00, c.div};
        if (c.fast)
            return (d << 1) + CNT_W'(FAST_LOW_OVH);
        else
            return d + CNT_W'(STD_LOW_OVH);
    endfunction

    function automatic logic [CNT_W-1:0] high_len_f(rate_cfg_t c);
        return {2'b00, c.div} + CNT_W'(HIGH_OVH);
    endfunction

endpackage

// File: rtl/scl_rate_regs.sv
module scl_rate_regs
    import scl_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    output rate_cfg_t         cfg,
    output logic [BAND_W-1:0] band
);
    logic [REG_W-1:0]  rate_q;
    logic [HI_W-1:0]   ext_q;
    logic [BAND_W-1:0] band_q;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
            ext_q  <= '0;
            band_q <= BAND_RST;
        end else if (wr_en) begin
            case (sel)
                SEL_RATE:     rate_q <= wr_data;
                SEL_RATE_EXT: ext_q  <= wr_data[HI_W-1:0];
                SEL_BAND:     band_q <= wr_data[REG_W-1 -: BAND_W];
                default:      ;
            endcase
        end
    end

    assign cfg.fast = rate_q[REG_W-1];
    assign cfg.div  = {ext_q, rate_q[LO_W-1:0]};
    assign band     = band_q;
endmodule

// File: rtl/scl_phase_calc.sv
module scl_phase_calc
    import scl_div_pkg::*;
(
    input  rate_cfg_t  cfg,
    output phase_len_t lens
);
    always_comb begin
        lens.low_len  = low_len_f(cfg);
        lens.high_len = high_len_f(cfg);
        lens.legal    = (cfg.div >= DIV_W'(MIN_DIV));
    end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       scl_in,
    input  phase_len_t lens,
    output logic       drive_low,
    output logic       change_stb,
    output logic       sample_stb,
    output phase_e     phase
);
    phase_e           state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hi_len_q;
    logic [CNT_W-1:0] hi_mid;
    logic             fell_q;
    logic             chg_q;

    assign hi_mid = (hi_len_q - CNT_W'(1)) >> 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PH_IDLE;
            cnt_q    <= '0;
            hi_len_q <= '0;
            fell_q   <= 1'b0;
            chg_q    <= 1'b0;
        end else begin
            fell_q <= 1'b0;
            chg_q  <= fell_q && enable;
            case (state_q)
                PH_IDLE: begin
                    if (enable && lens.legal) begin
                        state_q  <= PH_LOW;
                        cnt_q    <= lens.low_len - CNT_W'(1);
                        hi_len_q <= lens.high_len;
                        fell_q   <= 1'b1;
                    end
                end
                PH_LOW: begin
                    if (!enable) begin
                        state_q <= PH_IDLE;
                    end else if (cnt_q == '0) begin
                        state_q <= PH_HIGH;
                        cnt_q   <= hi_len_q - CNT_W'(1);
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (!enable) begin
                        state_q <= PH_IDLE;
                    end else if (scl_in) begin
                        if (cnt_q != '0) begin
                            cnt_q <= cnt_q - CNT_W'(1);
                        end else if (lens.legal) begin
                            state_q  <= PH_LOW;
                            cnt_q    <= lens.low_len - CNT_W'(1);
                            hi_len_q <= lens.high_len;
                            fell_q   <= 1'b1;
                        end else begin
                            state_q <= PH_IDLE;
                        end
                    end
                end
                default: state_q <= PH_IDLE;
            endcase
        end
    end

    assign drive_low  = (state_q == PH_LOW);
    assign change_stb = chg_q;
    assign sample_stb = (state_q == PH_HIGH) && (cnt_q == hi_mid) && scl_in;
    assign phase      = state_q;
endmodule

// File: rtl/scl_divider_top.sv
module scl_divider_top
    import scl_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              scl_in,
    output logic              scl_drive_low,
    output logic              sda_change_stb,
    output logic              sda_sample_stb,
    output logic [BAND_W-1:0] clk_band
);
    rate_cfg_t        rate_cfg;
    phase_len_t       lens;
    phase_e           phase;
    logic [DIV_W-1:0] live_div;

    scl_rate_regs i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cfg     (rate_cfg),
        .band    (clk_band)
    );

    scl_phase_calc i_calc (
        .cfg  (rate_cfg),
        .lens (lens)
    );

    scl_phase_fsm i_fsm (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .scl_in     (scl_in),
        .lens       (lens),
        .drive_low  (scl_drive_low),
        .change_stb (sda_change_stb),
        .sample_stb (sda_sample_stb),
        .phase      (phase)
    );

    assign live_div = rate_cfg.div;
endmodule

// File: rtl/scl_divider_chk.sv
module scl_divider_chk
    import scl_div_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             scl_in,
    input logic             scl_drive_low,
    input logic             sda_change_stb,
    input logic             sda_sample_stb,
    input phase_e           phase,
    input logic [DIV_W-1:0] live_div
);
    assert_legal_start_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_drive_low) |-> ($past(live_div) >= DIV_W'(MIN_DIV)));

    assert_stretch_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HIGH && !scl_in && enable) |=> (phase == PH_HIGH));

    assert_change_in_low_R6: assert property (@(posedge clk) disable iff (rst)
        sda_change_stb |-> (scl_drive_low && $past(scl_drive_low)));

    assert_strobes_apart_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sda_change_stb, sda_sample_stb}));

    assert_sample_when_high_R7: assert property (@(posedge clk) disable iff (rst)
        sda_sample_stb |-> (phase == PH_HIGH && scl_in && !scl_drive_low));

    assert_disable_release_R9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (phase == PH_IDLE && !scl_drive_low));
endmodule

bind scl_divider_top scl_divider_chk i_chk (
    .clk            (clk),
    .rst            (rst),
    .enable         (enable),
    .scl_in         (scl_in),
    .scl_drive_low  (scl_drive_low),
    .sda_change_stb (sda_change_stb),
    .sda_sample_stb (sda_sample_stb),
    .phase          (phase),
    .live_div       (live_div)
);

// File: tb/test_scl_divider_top.sv
module test_scl_divider_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       stretch = 1'b0;
    logic       scl_in;
    logic       scl_drive_low;
    logic       sda_change_stb;
    logic       sda_sample_stb;
    logic [2:0] clk_band;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    assign scl_in = ~scl_drive_low & ~stretch;

    scl_divider_top i_scl_divider_top (
        .clk            (clk),
        .rst            (rst),
        .enable         (enable),
        .wr_en          (wr_en),
        .wr_sel         (wr_sel),
        .wr_data        (wr_data),
        .scl_in         (scl_in),
        .scl_drive_low  (scl_drive_low),
        .sda_change_stb (sda_change_stb),
        .sda_sample_stb (sda_sample_stb),
        .clk_band       (clk_band)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_low(input bit fast, input int d);
        return fast ? 2 * d + 6 : d + 4;
    endfunction

    function automatic int exp_high(input int d);
        return d + 3;
    endfunction

    function automatic int exp_smp(input int h);
        return h - 1 - ((h - 1) / 2);
    endfunction

    task automatic write_reg(input logic [1:0] sel, input logic [7:0] data);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic set_rate(input bit fast, input int d, input logic [2:0] junk);
        logic [11:0] dv;
        dv = 12'(d);
        write_reg(2'd0, {fast, dv[6:0]});
        write_reg(2'd1, {junk, dv[11:7]});
    endtask

    task automatic wait_rise(input string req);
        int guard = 0;
        while (scl_drive_low && guard < 30000) begin
            @(negedge clk);
            guard++;
        end
        while (!scl_drive_low && guard < 30000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 30000) chk(1'b0, req, guard, 0);
    endtask

    task automatic measure(input bit fast, input int d, input int s, input string req);
        int lc = 0;
        int hc = 0;
        int nchg = 0;
        int chg_at = -1;
        int nsmp = 0;
        int smp_at = -1;
        int h;
        wait_rise(req);
        if (s > 0) stretch = 1'b1;
        while (scl_drive_low && lc < 30000) begin
            if (sda_change_stb) begin
                nchg++;
                chg_at = lc;
            end
            lc++;
            @(negedge clk);
        end
        while (!scl_drive_low && hc < 30000) begin
            if (sda_sample_stb) begin
                nsmp++;
                smp_at = hc;
            end
            hc++;
            if (hc == s) stretch = 1'b0;
            @(negedge clk);
        end
        stretch = 1'b0;
        h = exp_high(d) + ((s > 0) ? s - 1 : 0);
        chk(lc == exp_low(fast, d), {req, " low"}, lc, exp_low(fast, d));
        chk(hc == h, (s > 0) ? "R5 released time" : {req, " high"}, hc, h);
        chk(nchg == 1 && chg_at == 1, "R6 change strobe index", chg_at, 1);
        chk(nsmp == 1 && smp_at == exp_smp(exp_high(d)) + ((s > 0) ? s - 1 : 0),
            "R7 sample strobe index", smp_at, exp_smp(exp_high(d)) + ((s > 0) ? s - 1 : 0));
    endtask

    task automatic expect_idle(input int n, input string req);
        int lows = 0;
        int strobes = 0;
        for (int i = 0; i < n; i++) begin
            if (scl_drive_low) lows++;
            if (sda_change_stb || sda_sample_stb) strobes++;
            @(negedge clk);
        end
        chk(lows == 0 && strobes == 0, req, lows + strobes, 0);
    endtask

    initial begin
        int lc;
        int hc;
        void'($urandom(32'd24680));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state, R8 band reset value
        chk(scl_drive_low == 1'b0, "R11 released after reset", int'(scl_drive_low), 0);
        chk(!sda_change_stb && !sda_sample_stb, "R11 strobes low",
            int'(sda_change_stb) + int'(sda_sample_stb), 0);
        chk(clk_band == 3'b010, "R8 band reset", int'(clk_band), 2);

        // R4: divider 0 from reset, enabled
        enable = 1'b1;
        expect_idle(100, "R4 divider 0 idle");
        // R4: divider 1
        set_rate(1'b0, 1, 3'b000);
        expect_idle(100, "R4 divider 1 idle");

        // R2 minimum legal divider, R3 minimum in fast mode
        set_rate(1'b0, 2, 3'b000);
        measure(1'b0, 2, 0, "R2");
        set_rate(1'b1, 2, 3'b000);
        measure(1'b1, 2, 0, "R3");

        // R9 disable releases next clock, enable starts next clock
        set_rate(1'b0, 30, 3'b000);
        wait_rise("R9");
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(scl_drive_low == 1'b0, "R9 release after disable", int'(scl_drive_low), 0);
        expect_idle(50, "R9 stays idle while disabled");
        enable = 1'b1;
        @(negedge clk);
        chk(scl_drive_low == 1'b1, "R9 start after enable", int'(scl_drive_low), 1);

        // R5 stretching in both modes
        set_rate(1'b0, 10, 3'b000);
        measure(1'b0, 10, 7, "R2");
        set_rate(1'b1, 5, 3'b000);
        measure(1'b1, 5, 3, "R3");

        // R10 write during a period affects the next period only
        set_rate(1'b0, 20, 3'b000);
        wait_rise("R10");
        write_reg(2'd0, {1'b0, 7'd50});
        lc = 1;
        while (scl_drive_low && lc < 30000) begin
            lc++;
            @(negedge clk);
        end
        hc = 0;
        while (!scl_drive_low && hc < 30000) begin
            hc++;
            @(negedge clk);
        end
        chk(lc == 24, "R10 current low keeps old divider", lc, 24);
        chk(hc == 23, "R10 current high keeps old divider", hc, 23);
        measure(1'b0, 50, 0, "R10");

        // R1 ignored select code and junk bits in extension register
        write_reg(2'd3, 8'hFF);
        measure(1'b0, 50, 0, "R1");
        set_rate(1'b0, 1234, 3'b111);
        measure(1'b0, 1234, 0, "R1");

        // R8 band field write, low bits ignored
        write_reg(2'd2, 8'b101_10101);
        @(negedge clk);
        chk(clk_band == 3'b101, "R8 band write", int'(clk_band), 5);

        // R1/R2/R3 random spread of dividers and modes
        for (int k = 0; k < 8; k++) begin
            bit f;
            int d;
            f = 1'($urandom % 2);
            d = 2 + int'($urandom % 400);
            set_rate(f, d, 3'($urandom % 8));
            measure(f, d, 0, f ? "R3" : "R2");
        end

        // R4 illegal divider at a period boundary
        set_rate(1'b1, 0, 3'b000);
        repeat (3000) @(negedge clk);
        expect_idle(200, "R4 idle after boundary");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule